// File: doc/BRIEF.md
# Per-pin GPIO interrupt detector

This block turns eight already-synchronised GPIO input bits into interrupt requests. Software picks, for each pin separately, whether the pin requests service while it sits at a given level or when it changes. In the changing case the pin can react to a rising edge, a falling edge or either edge. A pin set to either edge does not look at its polarity bit.

Edge events are held in a raw status register until software writes a one to the matching bit of the clear register. Level conditions are not held: their raw status bit tracks the pin directly. An enable register masks the raw status into a masked status. The OR of the masked status drives a single interrupt line towards the interrupt controller.

Register access uses a simple bus. A write takes effect on the clock edge where it is strobed. Reads are combinational from the address.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the sense, both-edge, polarity and enable registers read 0, raw and masked status read 0 and `irq` is 0.
- R2: A pin whose sense bit (register 0x404) is 1 is level sensed. Its raw status bit (0x414) is 1 exactly while the pin equals its polarity bit (0x40C; 1 = high, 0 = low), and it drops when the level goes away without any clear.
- R3: A pin whose sense bit is 0 and both-edge bit (0x408) is 0 latches an event on a rising edge when its polarity bit is 1, or on a falling edge when the bit is 0. The opposite edge sets nothing.
- R4: A pin whose both-edge bit is 1 (sense 0) latches an event on either edge, whatever its polarity bit.
- R5: A latched edge event stays set in raw status until cleared, including while its enable bit (0x410) is 0.
- R6: Writing a 1 to bit n of the clear register (0x41C) clears the latched edge event of pin n. Writing 0 changes nothing. The clear register reads 0.
- R7: Masked status (0x418) equals raw status ANDed with the enable register. `irq` is 1 exactly when any masked bit is 1.
- R8: When a new edge and a clear for the same pin occur in the same cycle, the event stays set.
- R9: Rewriting sense, both-edge or polarity configuration while the pin is steady creates no edge event. Edges are found only by comparing the current sample of a pin with its previous sample.
- R10: The sense, both-edge, polarity and enable registers read back the last value written at their addresses. Addresses outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pin_in | input | 8 | Synchronised GPIO input bits |
| irq | output | 1 | Combined interrupt request |

## Verification
Level sensing is driven with both polarities on two pins at once. This shows that the status follows the pin, and that it is not held once the pin returns. Rising-only and falling-only pins receive both edge directions, which separates the chosen edge from the ignored one. An either-edge pin with its polarity bit set both ways shows that the override ignores polarity. Three further patterns complete the set: clears written with zero and non-zero data, an edge coinciding with a clear, and configuration rewritten under a steady high pin. These separate a true acknowledge from a spurious or lost event.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPIN = 8,
  parameter int AW = 12,
  parameter logic [AW-1:0] A_SENSE = 12'h404,
  parameter logic [AW-1:0] A_BOTH  = 12'h408,
  parameter logic [AW-1:0] A_POL   = 12'h40C,
  parameter logic [AW-1:0] A_EN    = 12'h410,
  parameter logic [AW-1:0] A_RAW   = 12'h414,
  parameter logic [AW-1:0] A_MASK  = 12'h418,
  parameter logic [AW-1:0] A_CLR   = 12'h41C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic            irq
);
  logic [NPIN-1:0] sense_q, both_q, pol_q, ie_q, prev_q, edge_q;
  logic            armed_q;
  logic [NPIN-1:0] clr_v, rise, fall, hit, edge_d, raw, masked;

  assign clr_v  = (bus_wr && bus_addr == A_CLR) ? bus_wdata : '0;
  assign rise   = pin_in & ~prev_q & {NPIN{armed_q}};
  assign fall   = ~pin_in & prev_q & {NPIN{armed_q}};
  assign hit    = (both_q & (rise | fall)) | (~both_q & pol_q & rise) | (~both_q & ~pol_q & fall);
  assign edge_d = ~sense_q & (hit | (edge_q & ~clr_v));
  assign raw    = (sense_q & ~(pin_in ^ pol_q)) | (~sense_q & edge_q);
  assign masked = raw & ie_q;
  assign irq    = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ie_q    <= '0;
      prev_q  <= '0;
      edge_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= pin_in;
      armed_q <= 1'b1;
      edge_q  <= edge_d;
      if (bus_wr && bus_addr == A_SENSE) sense_q <= bus_wdata;
      if (bus_wr && bus_addr == A_BOTH)  both_q  <= bus_wdata;
      if (bus_wr && bus_addr == A_POL)   pol_q   <= bus_wdata;
      if (bus_wr && bus_addr == A_EN)    ie_q    <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_SENSE: bus_rdata = sense_q;
      A_BOTH:  bus_rdata = both_q;
      A_POL:   bus_rdata = pol_q;
      A_EN:    bus_rdata = ie_q;
      A_RAW:   bus_rdata = raw;
      A_MASK:  bus_rdata = masked;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] pin_in,
  input logic [NPIN-1:0] prev_q,
  input logic [NPIN-1:0] sense_q,
  input logic [NPIN-1:0] ie_q,
  input logic [NPIN-1:0] edge_q,
  input logic [NPIN-1:0] clr_v,
  input logic            irq
);
  AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |=> (sense_q == '0 && ie_q == '0 && edge_q == '0 && !irq)); // R1
  AST_LEVEL_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (edge_q & $past(sense_q)) == '0); // R2
  AST_EVENT_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n) ($past(edge_q & ~clr_v & ~sense_q) & ~edge_q) == '0); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n) ($past(clr_v & ~(pin_in ^ prev_q)) & edge_q) == '0); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (ie_q != '0)); // R7
  AST_NO_SPURIOUS_EVENT: assert property (@(posedge clk) disable iff (!rst_n) ((edge_q & ~$past(edge_q)) & ~$past(pin_in ^ prev_q)) == '0); // R9
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .prev_q(prev_q), .sense_q(sense_q),
  .ie_q(ie_q), .edge_q(edge_q), .clr_v(clr_v), .irq(irq)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
  localparam logic [11:0] SEN = 12'h404, BTH = 12'h408, POL = 12'h40C, EN = 12'h410,
                          RAW = 12'h414, MSK = 12'h418, CLR = 12'h41C;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, irq;
  logic [11:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, pins = '0;
  int errors = 0, total = 0;

  always #2 clk = ~clk;

  gpio_irq_detect u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins), .irq(irq));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [7:0] exp);
    @(negedge clk); bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic setp(input logic [7:0] v);
    @(negedge clk); pins = v;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] s, input logic [7:0] b, input logic [7:0] p, input logic [7:0] e);
    wr(SEN, s); wr(BTH, b); wr(POL, p); wr(EN, e);
  endtask

  task automatic t_reset;
    rd_chk("R1 sense", SEN, 8'h00); rd_chk("R1 both", BTH, 8'h00);
    rd_chk("R1 pol", POL, 8'h00);   rd_chk("R1 en", EN, 8'h00);
    rd_chk("R1 raw", RAW, 8'h00);   rd_chk("R1 masked", MSK, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_level;
    cfg(8'h03, 8'h00, 8'h01, 8'h00);
    rd_chk("R2 low pins", RAW, 8'h02);
    setp(8'h03);
    rd_chk("R2 high pins", RAW, 8'h01);
    wr(EN, 8'h03);
    rd_chk("R7 level masked", MSK, 8'h01);
    check("R7 level irq", {7'd0, irq}, 8'h01);
    setp(8'h02);
    rd_chk("R2 level gone", RAW, 8'h00);
    check("R2 irq drops", {7'd0, irq}, 8'h00);
    setp(8'h00);
    cfg(8'h00, 8'h00, 8'h00, 8'h00);
    rd_chk("R2 no leftover", RAW, 8'h00);
  endtask

  task automatic t_edge;
    cfg(8'h00, 8'h00, 8'h04, 8'h00);
    setp(8'h0C);
    rd_chk("R3 rise only on rising pin", RAW, 8'h04);
    setp(8'h00);
    rd_chk("R3 fall on falling pin", RAW, 8'h0C);
    check("R5 irq off with enable 0", {7'd0, irq}, 8'h00);
    setp(8'h00);
    rd_chk("R5 still latched", RAW, 8'h0C);
    wr(CLR, 8'h00);
    rd_chk("R6 zero clear no effect", RAW, 8'h0C);
    wr(CLR, 8'h04);
    rd_chk("R6 partial clear", RAW, 8'h08);
    wr(CLR, 8'h08);
    rd_chk("R6 full clear", RAW, 8'h00);
    rd_chk("R6 clear reads 0", CLR, 8'h00);
  endtask

  task automatic t_both;
    cfg(8'h00, 8'h10, 8'h00, 8'h00);
    setp(8'h10);
    rd_chk("R4 rise pol0", RAW, 8'h10);
    wr(CLR, 8'h10);
    setp(8'h00);
    rd_chk("R4 fall pol0", RAW, 8'h10);
    wr(CLR, 8'h10); wr(POL, 8'h10);
    setp(8'h10);
    rd_chk("R4 rise pol1", RAW, 8'h10);
    wr(CLR, 8'h10);
    setp(8'h00);
    rd_chk("R4 fall pol1", RAW, 8'h10);
    wr(CLR, 8'h10);
    rd_chk("R4 cleared", RAW, 8'h00);
  endtask

  task automatic t_mask;
    cfg(8'h00, 8'h00, 8'h20, 8'h00);
    setp(8'h20);
    rd_chk("R7 masked off", MSK, 8'h00);
    check("R7 irq off", {7'd0, irq}, 8'h00);
    wr(EN, 8'h20);
    rd_chk("R7 masked on", MSK, 8'h20);
    check("R7 irq on", {7'd0, irq}, 8'h01);
    wr(EN, 8'hDF);
    rd_chk("R7 other bits", MSK, 8'h00);
    check("R7 irq other bits", {7'd0, irq}, 8'h00);
    setp(8'h00);
    wr(CLR, 8'h20); wr(EN, 8'h00);
  endtask

  task automatic t_race;
    cfg(8'h00, 8'h00, 8'h40, 8'h00);
    setp(8'h40);
    setp(8'h00);
    rd_chk("R8 setup", RAW, 8'h40);
    @(negedge clk); pins = 8'h40; bus_addr = CLR; bus_wdata = 8'h40; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd_chk("R8 edge beats clear", RAW, 8'h40);
    wr(CLR, 8'h40);
    rd_chk("R8 later clear", RAW, 8'h00);
    setp(8'h00);
    wr(CLR, 8'h40);
  endtask

  task automatic t_cfg;
    cfg(8'h00, 8'h00, 8'h00, 8'h00);
    setp(8'h80);
    rd_chk("R9 rise ignored in falling mode", RAW, 8'h00);
    wr(POL, 8'h80); wr(BTH, 8'h80);
    wr(SEN, 8'h80); wr(SEN, 8'h00); wr(BTH, 8'h00);
    setp(8'h80);
    rd_chk("R9 no event from config", RAW, 8'h00);
    setp(8'h00);
    rd_chk("R9 falling ignored rising mode", RAW, 8'h00);
  endtask

  task automatic t_map;
    wr(SEN, 8'h5A); wr(EN, 8'hA5); wr(BTH, 8'h3C); wr(POL, 8'hC3);
    rd_chk("R10 sense", SEN, 8'h5A); rd_chk("R10 en", EN, 8'hA5);
    rd_chk("R10 both", BTH, 8'h3C);  rd_chk("R10 pol", POL, 8'hC3);
    rd_chk("R10 unmapped", 12'h400, 8'h00);
    cfg(8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_level; t_edge; t_both; t_mask; t_race; t_cfg; t_map;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    #400000;
    errors++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule